// File: doc/BRIEF.md
# Windowed Correntropy Scorer with Peak Tracking

This block scores how closely each incoming image window matches a fixed reference kernel. Each cycle it takes every pixel of one window together with the matching kernel pixel and forms their absolute difference. It maps that difference through a programmable bell-shaped weight table of 64 entries and adds the weights of all window positions into a single similarity score. The table's out-of-range path gives no weight to large differences, and the sum is built by a registered adder tree. A new window can enter on every clock, and a score leaves on every clock after a fixed latency.

Scores that belong to a frame pass through a small tracker built around a three-state controller. The states are ST_IDLE (no frame in progress), ST_TRACK (collecting scores) and ST_FLAG (a one-cycle frame-complete indication). The transitions are:

- start: IDLE or FLAG to TRACK, on a score tagged as first of frame.
- finish: TRACK to FLAG, on the last score of the frame.
- rest: FLAG to IDLE, when no new frame starts.

While it tracks, the tracker keeps the two best scores of the frame and the output row and column at which each one arose. These values stay on the outputs after the frame ends, until the next frame begins. The weight table is written through a simple address/data/enable port while no frame is being tracked.

Top module: `corr_top2`

## Requirements
- R1: For each valid window, `corr_out` equals the sum over all NTAPS positions of T[|w - k|]. Here w is the window pixel, k is the kernel pixel and T is the 8-bit unsigned weight table. Tap t occupies bits [t*PIX_W +: PIX_W] of `win_pix` and `kern_pix`.
- R2: A position whose absolute difference is 64 or more contributes zero, whatever the table holds. This applies whether the pixel lies above or below the kernel value.
- R3: `corr_valid` and `corr_out` appear exactly LEVELS+2 clock edges after the edge that samples `in_valid`, where LEVELS = clog2(NTAPS). Back-to-back windows give back-to-back scores.
- R4: A score tagged as first of frame (the `in_sof` of its window) clears both maxima before it is compared, and that score sits at row 0, column 0.
- R5: The maxima change only at a tracked score, and only when the score strictly beats a held value:
  - If the score is above max1, the old max1 with its coordinates moves to max2 and the score becomes max1.
  - Else, if the score is above max2, it replaces max2.
  - Equal values displace nothing.
- R6: `max1_val` is never below `max2_val`.
- R7: Tracked scores are numbered in raster order. The column counts from 0 to FRAME_COLS-1, after which the row advances. Each maximum carries the row and column of the score that set it.
- R8: `frame_done` is high for exactly one cycle, in the cycle right after the FRAME_ROWS*FRAME_COLS-th tracked score.
- R9: A score that arrives in ST_IDLE without a first-of-frame tag leaves both maxima and their coordinates unchanged.
- R10: A table write (`tbl_we` with `tbl_addr`, `tbl_data`) takes effect when the tracker is not in ST_TRACK. A write made while a frame is being tracked is ignored.
- R11: After reset, `corr_valid` and `frame_done` are low, both maxima and coordinates are zero, and every table entry is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Window present this cycle |
| in_sof | input | 1 | Window is the first of a frame |
| win_pix | input | NTAPS*PIX_W (144) | Window pixels, tap t at [t*PIX_W +: PIX_W] |
| kern_pix | input | NTAPS*PIX_W (144) | Kernel pixels, same layout |
| tbl_we | input | 1 | Weight table write enable |
| tbl_addr | input | 6 | Weight table entry |
| tbl_data | input | 8 | Weight value |
| corr_valid | output | 1 | Score present |
| corr_out | output | SUM_W (12) | Correntropy score |
| frame_done | output | 1 | One-cycle frame-complete pulse |
| max1_val | output | SUM_W (12) | Highest score of the frame |
| max1_row | output | ROW_W (2) | Row of highest score |
| max1_col | output | COL_W (2) | Column of highest score |
| max2_val | output | SUM_W (12) | Second highest score |
| max2_row | output | ROW_W (2) | Row of second score |
| max2_col | output | COL_W (2) | Column of second score |

## Verification
A window sampled at one edge yields its score LEVELS+2 edges later (6 for the default 3x3 window). The bench measures that distance in cycle numbers on an isolated window and records every later score as it appears on a falling edge, so scores are compared in order and not at an assumed cycle. The maxima settle at the edge that samples the last score. `frame_done` is due in the cycle after that score, and the bench checks it against the cycle number of the last recorded score and counts its high cycles. The maxima are read only after the pipeline has drained.

// File: rtl/corr_pkg.sv
package corr_pkg;
    localparam int GAUSS_W   = 8;
    localparam int LUT_DEPTH = 64;
    localparam int LUT_AW    = 6;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRACK = 2'd1,
        ST_FLAG  = 2'd2
    } trk_state_t;
endpackage

// File: rtl/corr_gauss_stage.sv
module corr_gauss_stage import corr_pkg::*; #(
    parameter int PIX_W = 16,
    parameter int NTAPS = 9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic                       in_sof,
    input  logic [NTAPS*PIX_W-1:0]     win_pix,
    input  logic [NTAPS*PIX_W-1:0]     kern_pix,
    input  logic                       tbl_we,
    input  logic [LUT_AW-1:0]          tbl_addr,
    input  logic [GAUSS_W-1:0]         tbl_data,
    input  logic                       tbl_lock,
    output logic                       g_valid,
    output logic                       g_sof,
    output logic [NTAPS*GAUSS_W-1:0]   g_flat
);
    logic [GAUSS_W-1:0] lut [LUT_DEPTH];
    logic [PIX_W-1:0]   diff_c [NTAPS];
    logic [PIX_W-1:0]   diff_q [NTAPS];
    logic               far_q  [NTAPS];
    logic               v1, s1;

    // weight table, writable only outside a tracked frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LUT_DEPTH; i++) lut[i] <= '0;
        end else if (tbl_we && !tbl_lock) begin
            lut[tbl_addr] <= tbl_data;
        end
    end

    always_comb begin
        for (int t = 0; t < NTAPS; t++) begin
            if (win_pix[t*PIX_W +: PIX_W] >= kern_pix[t*PIX_W +: PIX_W])
                diff_c[t] = win_pix[t*PIX_W +: PIX_W] - kern_pix[t*PIX_W +: PIX_W];
            else
                diff_c[t] = kern_pix[t*PIX_W +: PIX_W] - win_pix[t*PIX_W +: PIX_W];
        end
    end

    // stage 1: absolute difference and range flag
    always_ff @(posedge clk) begin
        for (int t = 0; t < NTAPS; t++) begin
            diff_q[t] <= diff_c[t];
            far_q[t]  <= (diff_c[t] >= PIX_W'(LUT_DEPTH));
        end
    end

    // stage 2: table weight, zero for out-of-range differences
    always_ff @(posedge clk) begin
        for (int t = 0; t < NTAPS; t++) begin
            g_flat[t*GAUSS_W +: GAUSS_W] <= far_q[t] ? '0 : lut[diff_q[t][LUT_AW-1:0]];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1 <= 1'b0; s1 <= 1'b0; g_valid <= 1'b0; g_sof <= 1'b0;
        end else begin
            v1 <= in_valid;     s1 <= in_valid & in_sof;
            g_valid <= v1;      g_sof <= s1;
        end
    end
endmodule

// File: rtl/corr_sum_tree.sv
module corr_sum_tree #(
    parameter int NTAPS  = 9,
    parameter int IN_W   = 8,
    parameter int LEVELS = $clog2(NTAPS),
    parameter int SUM_W  = IN_W + LEVELS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sof,
    input  logic [NTAPS*IN_W-1:0]   in_flat,
    output logic                    out_valid,
    output logic                    out_sof,
    output logic [SUM_W-1:0]        sum
);
    localparam int P    = 1 << LEVELS;
    localparam int HALF = P / 2;
    localparam int QUAR = P / 4;

    logic [SUM_W-1:0] lv0 [P];
    logic [SUM_W-1:0] tr  [LEVELS][HALF];
    logic [LEVELS-1:0] vp, sp;

    always_comb begin
        for (int j = 0; j < NTAPS; j++) lv0[j] = SUM_W'(in_flat[j*IN_W +: IN_W]);
        for (int j = NTAPS; j < P; j++) lv0[j] = '0;
    end

    always_ff @(posedge clk) begin
        for (int j = 0; j < HALF; j++) tr[0][j] <= lv0[2*j] + lv0[2*j+1];
        for (int l = 1; l < LEVELS; l++) begin
            for (int j = 0; j < QUAR; j++) begin
                if (j < (P >> (l + 1))) tr[l][j] <= tr[l-1][2*j] + tr[l-1][2*j+1];
                else                    tr[l][j] <= '0;
            end
            for (int j = QUAR; j < HALF; j++) tr[l][j] <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vp <= '0; sp <= '0;
        end else begin
            vp <= {vp, in_valid};
            sp <= {sp, in_sof};
        end
    end

    assign sum       = tr[LEVELS-1][0];
    assign out_valid = vp[LEVELS-1];
    assign out_sof   = sp[LEVELS-1];
endmodule

// File: rtl/corr_peak_tracker.sv
module corr_peak_tracker import corr_pkg::*; #(
    parameter int SUM_W = 12,
    parameter int ROWS  = 3,
    parameter int COLS  = 4,
    parameter int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    parameter int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              r_valid,
    input  logic              r_sof,
    input  logic [SUM_W-1:0]  r_sum,
    output logic              frame_done,
    output logic              tbl_lock,
    output logic [SUM_W-1:0]  max1_val,
    output logic [ROW_W-1:0]  max1_row,
    output logic [COL_W-1:0]  max1_col,
    output logic [SUM_W-1:0]  max2_val,
    output logic [ROW_W-1:0]  max2_row,
    output logic [COL_W-1:0]  max2_col
);
    trk_state_t state, nxt;
    logic [ROW_W-1:0] row_c, pos_row;
    logic [COL_W-1:0] col_c, pos_col;
    logic             take, at_last, row_end;
    logic [SUM_W-1:0] b1_val, b2_val;
    logic [ROW_W-1:0] b1_row;
    logic [COL_W-1:0] b1_col;

    assign take    = r_valid && (r_sof || state == ST_TRACK);
    assign pos_row = r_sof ? '0 : row_c;
    assign pos_col = r_sof ? '0 : col_c;
    assign row_end = (pos_col == COL_W'(COLS - 1));
    assign at_last = row_end && (pos_row == ROW_W'(ROWS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions: start, finish, rest
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (take) nxt = at_last ? ST_FLAG : ST_TRACK;
            ST_TRACK: if (take && at_last) nxt = ST_FLAG;
            ST_FLAG:  if (take) nxt = at_last ? ST_FLAG : ST_TRACK;
                      else      nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        frame_done = 1'b0;
        tbl_lock   = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_TRACK: tbl_lock   = 1'b1;
            ST_FLAG:  frame_done = 1'b1;
            default:  ;
        endcase
    end

    // held maxima as seen by the incoming score (cleared on a frame start)
    assign b1_val = r_sof ? '0 : max1_val;
    assign b1_row = r_sof ? '0 : max1_row;
    assign b1_col = r_sof ? '0 : max1_col;
    assign b2_val = r_sof ? '0 : max2_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            max1_val <= '0; max1_row <= '0; max1_col <= '0;
            max2_val <= '0; max2_row <= '0; max2_col <= '0;
            row_c    <= '0; col_c    <= '0;
        end else if (take) begin
            if (r_sum > b1_val) begin
                max2_val <= b1_val; max2_row <= b1_row; max2_col <= b1_col;
                max1_val <= r_sum;  max1_row <= pos_row; max1_col <= pos_col;
            end else if (r_sum > b2_val) begin
                max1_val <= b1_val; max1_row <= b1_row; max1_col <= b1_col;
                max2_val <= r_sum;  max2_row <= pos_row; max2_col <= pos_col;
            end else if (r_sof) begin
                max1_val <= '0; max1_row <= '0; max1_col <= '0;
                max2_val <= '0; max2_row <= '0; max2_col <= '0;
            end
            if (at_last) begin
                row_c <= '0; col_c <= '0;
            end else if (row_end) begin
                row_c <= pos_row + 1'b1; col_c <= '0;
            end else begin
                row_c <= pos_row; col_c <= pos_col + 1'b1;
            end
        end
    end
endmodule

// File: rtl/corr_top2.sv
module corr_top2 import corr_pkg::*; #(
    parameter int PIX_W      = 16,
    parameter int WIN_H      = 3,
    parameter int WIN_W      = 3,
    parameter int FRAME_ROWS = 3,
    parameter int FRAME_COLS = 4,
    localparam int NTAPS  = WIN_H * WIN_W,
    localparam int LEVELS = $clog2(NTAPS),
    localparam int SUM_W  = GAUSS_W + LEVELS,
    localparam int ROW_W  = (FRAME_ROWS > 1) ? $clog2(FRAME_ROWS) : 1,
    localparam int COL_W  = (FRAME_COLS > 1) ? $clog2(FRAME_COLS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_sof,
    input  logic [NTAPS*PIX_W-1:0] win_pix,
    input  logic [NTAPS*PIX_W-1:0] kern_pix,
    input  logic                   tbl_we,
    input  logic [LUT_AW-1:0]      tbl_addr,
    input  logic [GAUSS_W-1:0]     tbl_data,
    output logic                   corr_valid,
    output logic [SUM_W-1:0]       corr_out,
    output logic                   frame_done,
    output logic [SUM_W-1:0]       max1_val,
    output logic [ROW_W-1:0]       max1_row,
    output logic [COL_W-1:0]       max1_col,
    output logic [SUM_W-1:0]       max2_val,
    output logic [ROW_W-1:0]       max2_row,
    output logic [COL_W-1:0]       max2_col
);
    logic                     g_valid, g_sof, t_sof, lock;
    logic [NTAPS*GAUSS_W-1:0] g_flat;

    corr_gauss_stage #(.PIX_W(PIX_W), .NTAPS(NTAPS)) u_gauss (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .win_pix(win_pix), .kern_pix(kern_pix),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data), .tbl_lock(lock),
        .g_valid(g_valid), .g_sof(g_sof), .g_flat(g_flat)
    );

    corr_sum_tree #(.NTAPS(NTAPS), .IN_W(GAUSS_W), .LEVELS(LEVELS), .SUM_W(SUM_W)) u_tree (
        .clk(clk), .rst_n(rst_n), .in_valid(g_valid), .in_sof(g_sof), .in_flat(g_flat),
        .out_valid(corr_valid), .out_sof(t_sof), .sum(corr_out)
    );

    corr_peak_tracker #(.SUM_W(SUM_W), .ROWS(FRAME_ROWS), .COLS(FRAME_COLS),
                        .ROW_W(ROW_W), .COL_W(COL_W)) u_track (
        .clk(clk), .rst_n(rst_n), .r_valid(corr_valid), .r_sof(t_sof), .r_sum(corr_out),
        .frame_done(frame_done), .tbl_lock(lock),
        .max1_val(max1_val), .max1_row(max1_row), .max1_col(max1_col),
        .max2_val(max2_val), .max2_row(max2_row), .max2_col(max2_col)
    );
endmodule

// File: rtl/corr_top2_chk.sv
module corr_top2_chk #(
    parameter int NTAPS = 9,
    parameter int SUM_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             corr_valid,
    input logic             frame_done,
    input logic [SUM_W-1:0] max1_val,
    input logic [SUM_W-1:0] max2_val
);
    localparam int LAT = $clog2(NTAPS) + 2;
    logic [LAT-1:0] vsh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vsh <= '0;
        else        vsh <= {vsh[LAT-2:0], in_valid};
    end

    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        corr_valid == vsh[LAT-1]);
    a_r6_order: assert property (@(posedge clk) disable iff (!rst_n)
        max1_val >= max2_val);
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
    a_r8_follows_result: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(corr_valid));
    a_r5_hold_between_results: assert property (@(posedge clk) disable iff (!rst_n)
        !corr_valid |=> ($stable(max1_val) && $stable(max2_val)));
endmodule

bind corr_top2 corr_top2_chk #(.NTAPS(NTAPS), .SUM_W(SUM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .corr_valid(corr_valid),
    .frame_done(frame_done), .max1_val(max1_val), .max2_val(max2_val)
);

// File: tb/test_corr_top2.sv
module test_corr_top2;
    localparam int CLK_PERIOD = 10;
    localparam int PIX_W  = 16;
    localparam int NTAPS  = 9;
    localparam int ROWS   = 3;
    localparam int COLS   = 4;
    localparam int NOUT   = ROWS * COLS;
    localparam int LEVELS = $clog2(NTAPS);
    localparam int SUM_W  = 8 + LEVELS;
    localparam int KVAL   = 1000;

    localparam int V_BASE [NOUT] = '{1000, 1000, 990, 1063, 1064, 936, 937, 0, 1000, 1000, 1000, 1020};
    localparam int V_STEP [NOUT] = '{0,    1,    3,   0,    0,    0,   0,   0, 100,  0,    8,    -1};

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_sof = 1'b0, tbl_we = 1'b0;
    logic [NTAPS*PIX_W-1:0] win_pix = '0, kern_pix = '0;
    logic [5:0] tbl_addr = '0;
    logic [7:0] tbl_data = '0;
    logic corr_valid, frame_done;
    logic [SUM_W-1:0] corr_out, max1_val, max2_val;
    logic [1:0] max1_row, max1_col, max2_row, max2_col;

    corr_top2 i_corr_top2 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .win_pix(win_pix), .kern_pix(kern_pix),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .corr_valid(corr_valid), .corr_out(corr_out), .frame_done(frame_done),
        .max1_val(max1_val), .max1_row(max1_row), .max1_col(max1_col),
        .max2_val(max2_val), .max2_row(max2_row), .max2_col(max2_col)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int got[$];
    int last_v_cyc = 0, first_v_cyc = -1, done_cyc = 0, done_cnt = 0, send_cyc = 0;
    int tbl_m [64];
    int fb [NOUT];
    int fs [NOUT];
    int wr_at = -1, wr_addr = 0, wr_data = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (corr_valid) begin
                got.push_back(int'(corr_out));
                last_v_cyc = cyc;
                if (first_v_cyc < 0) first_v_cyc = cyc;
            end
            if (frame_done) begin
                done_cnt++;
                done_cyc = cyc;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_corr(input int base, input int step);
        int s = 0;
        for (int t = 0; t < NTAPS; t++) begin
            int p = (base + step * t) & 16'hFFFF;
            int d = (p > KVAL) ? p - KVAL : KVAL - p;
            s += (d >= 64) ? 0 : tbl_m[d];
        end
        return s;
    endfunction

    task automatic send(input int base, input int step, input bit sof);
        @(negedge clk);
        send_cyc = cyc;
        in_valid = 1'b1;
        in_sof   = sof;
        tbl_we   = 1'b0;
        for (int t = 0; t < NTAPS; t++) win_pix[t*PIX_W +: PIX_W] = PIX_W'(base + step * t);
    endtask

    task automatic idle_in();
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; tbl_we = 1'b0;
    endtask

    task automatic write_tbl(input int a, input int d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = 6'(a); tbl_data = 8'(d);
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // one frame from fb/fs; expected values built from R1, R2, R4, R5, R7
    task automatic run_frame(input string tag);
        int e [NOUT];
        int m1 = 0, m1r = 0, m1c = 0, m2 = 0, m2r = 0, m2c = 0;
        for (int i = 0; i < NOUT; i++) e[i] = exp_corr(fb[i], fs[i]);
        got.delete();
        done_cnt = 0;
        for (int i = 0; i < NOUT; i++) begin
            send(fb[i], fs[i], i == 0);
            if (i == wr_at) begin
                tbl_we = 1'b1; tbl_addr = 6'(wr_addr); tbl_data = 8'(wr_data);
            end
        end
        idle_in();
        repeat (LEVELS + 8) @(negedge clk);
        check({tag, " R3 score count"}, got.size(), NOUT);
        for (int i = 0; i < NOUT && i < got.size(); i++)
            check($sformatf("%s R1/R2 score %0d", tag, i), got[i], e[i]);
        for (int i = 0; i < NOUT; i++) begin
            if (e[i] > m1) begin
                m2 = m1; m2r = m1r; m2c = m1c;
                m1 = e[i]; m1r = i / COLS; m1c = i % COLS;
            end else if (e[i] > m2) begin
                m2 = e[i]; m2r = i / COLS; m2c = i % COLS;
            end
        end
        check({tag, " R5 max1 value"}, int'(max1_val), m1);
        check({tag, " R7 max1 row"},   int'(max1_row), m1r);
        check({tag, " R7 max1 col"},   int'(max1_col), m1c);
        check({tag, " R5 max2 value"}, int'(max2_val), m2);
        check({tag, " R7 max2 row"},   int'(max2_row), m2r);
        check({tag, " R7 max2 col"},   int'(max2_col), m2c);
        check({tag, " R8 done width"}, done_cnt, 1);
        check({tag, " R8 done cycle"}, done_cyc, last_v_cyc + 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) tbl_m[i] = 0;
        for (int t = 0; t < NTAPS; t++) kern_pix[t*PIX_W +: PIX_W] = PIX_W'(KVAL);
        repeat (3) @(negedge clk);
        // R11: state held during reset
        check("R11 corr_valid in reset", int'(corr_valid), 0);
        check("R11 frame_done in reset", int'(frame_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 max1_val", int'(max1_val), 0);
        check("R11 max2_val", int'(max2_val), 0);
        check("R11 max coords", int'({max1_row, max1_col, max2_row, max2_col}), 0);

        // R11 table cleared, R3 latency on an isolated window
        got.delete(); first_v_cyc = -1;
        send(KVAL, 0, 1'b0);
        idle_in();
        repeat (LEVELS + 6) @(negedge clk);
        check("R3 single score seen", got.size(), 1);
        if (got.size() > 0) check("R11 zeroed table score", got[0], 0);
        check("R3 latency edges", first_v_cyc - send_cyc, LEVELS + 2);
        check("R9 idle score ignored", int'(frame_done), 0);

        // load the weight table while idle (R10)
        for (int i = 0; i < 64; i++) begin
            write_tbl(i, 255 - 4 * i);
            tbl_m[i] = 255 - 4 * i;
        end

        // frame 1: the stimulus table, including tie and out-of-range cases
        for (int i = 0; i < NOUT; i++) begin fb[i] = V_BASE[i]; fs[i] = V_STEP[i]; end
        run_frame("F1");

        // frame 2: R4 clear of the large frame-1 maxima, R10 write ignored mid-frame
        for (int i = 0; i < NOUT; i++) begin fb[i] = 1063; fs[i] = 0; end
        fb[5] = 1064;
        wr_at = 10; wr_addr = 63; wr_data = 200;
        run_frame("F2 R4 R10");
        wr_at = -1;

        // R9: a score without a frame start leaves the maxima alone
        got.delete();
        send(KVAL, 0, 1'b0);
        idle_in();
        repeat (LEVELS + 6) @(negedge clk);
        check("R9 stray score present", got.size(), 1);
        check("R9 max1 kept", int'(max1_val), 27);
        check("R9 max1 row kept", int'(max1_row), 0);
        check("R9 max2 kept", int'(max2_val), 27);
        check("R9 max2 col kept", int'(max2_col), 1);

        // R10: a write while idle takes effect
        write_tbl(63, 200);
        tbl_m[63] = 200;
        for (int i = 0; i < NOUT; i++) begin fb[i] = 1063; fs[i] = 0; end
        run_frame("F3 R10");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule